// File: doc/BRIEF.md
# External strobe timing generator

This block drives the select and enable strobes of an external bus that serves up to four peripheral banks. An internal requester presents a bank number, an address, a read or write flag and write data. The block accepts the request when it is idle, latches everything it needs, and then walks through a fixed order of phases. First the address is held with no select asserted. Then the chosen bank's chip select goes low while the strobe is still high. Then the read strobe (output enable) or the write strobe goes low for the access window. Last, the chip select is held low after the strobe has risen.

Each bank has its own length for each of the four phases. These lengths are written through a narrow register write port. Each 32-bit configuration word carries the timing of two banks, so two words cover four banks. The block returns a single-cycle done pulse at the end of each transfer. It keeps the data captured from the external bus on the last read until the next read replaces it. The timing of a bank is copied when a request is accepted, so a software update takes effect from the next transfer and never changes one already under way.

All external strobes are active low and sit high whenever no transfer is in progress.

Top module: `xio_strobe_gen`

## Requirements
- R1: After reset, every chip select, the output enable and the write enable are high, `req_ready` is 1, `xfer_done` is 0 and `rd_data` is 0. All four timing fields of every bank reset to 0.
- R2: A write with `cfg_we`=1 loads configuration word `cfg_sel`=s. Bits [15:0] hold the timing of bank 2s and bits [31:16] hold the timing of bank 2s+1. Inside each 16-bit half, [2:0] is the address setup A, [5:3] is the select setup C, [8:6] is the access value P, [11:9] is the hold H, and [15:12] is ignored. The next accepted request to that bank uses the new values.
- R3: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1; call the cycles that follow 1, 2, 3 and so on. From cycle 1 until the end of the transfer, `ext_addr` equals the accepted address. Only the chip select of the accepted bank goes low, first in cycle A+1.
- R4: The strobe (output enable for a read, write enable for a write) first goes low in cycle A+C+1, so the chip select leads it by C cycles.
- R5: The strobe stays low for exactly P+1 cycles (P=0 gives 1 cycle, P=7 gives 8 cycles).
- R6: The chip select stays low for H cycles after the strobe rises. With H=0, chip select and strobe rise together, and the transfer occupies A+C+P+1+H cycles.
- R7: A write (`req_write`=1) pulses `ext_we_n` with the timing of R4 to R6 and leaves `ext_oe_n` high. `ext_wdata` equals the accepted write data while the strobe is low. A read pulses `ext_oe_n` and leaves `ext_we_n` high.
- R8: `xfer_done` is 1 for exactly one cycle: the last cycle of the transfer (cycle A+C+P+1+H). `req_ready` is 0 from cycle 1 through that cycle and 1 in the cycle after it. A request presented while `req_ready` is 0, whatever its bank or address, has no effect on the strobes or on the address.
- R9: On a read, `rd_data` takes the value of `ext_rdata` at the rising edge that ends the last output-enable-low cycle. It is valid from the cycle after the strobe rises and holds until the next read. A write leaves `rd_data` unchanged.
- R10: The timing a transfer follows is the bank's setting at the edge where that transfer was accepted. A configuration write during the transfer does not change its phase lengths.
- R11: With A=0, C=0, P=4 and H=0, chip select and output enable are both low in cycles 1 to 5 only, and `xfer_done` is 1 in cycle 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 1 | Configuration word index |
| cfg_wdata | input | 32 | Configuration word data, two banks per word |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request taken at this edge |
| req_bank | input | 2 | Bank of the requested transfer |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| xfer_done | output | 1 | One-cycle pulse in the last cycle of a transfer |
| rd_data | output | 16 | Data captured by the last read |
| ext_addr | output | 16 | External address bus |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_cs_n | output | 4 | Chip select per bank, active low |
| ext_oe_n | output | 1 | Output enable (read strobe), active low |
| ext_we_n | output | 1 | Write enable, active low |

## Verification
A wrong phase or count inside the sequencer shows up at the external pins within the same transfer. The select or strobe edge moves by whole cycles, a second bank select appears, or the two strobes overlap, and a cycle-by-cycle comparison catches each of these in the first cycle it is wrong. A latched timing set that is stale or follows live updates only shows its effect as changed phase lengths once the transfer has started. Read capture on the wrong edge shows as a changed low byte of `rd_data`, because the bench's external data counts the enable-low cycles. A lost idle return shows as `req_ready` staying low, or as `xfer_done` missing or repeating, in the cycle after the expected end.

// File: rtl/xio_pkg.sv
package xio_pkg;

   localparam int FIELD_W    = 3;
   localparam int BANK_CFG_W = 16;

   typedef struct packed {
      logic [FIELD_W-1:0] hold;
      logic [FIELD_W-1:0] acc;
      logic [FIELD_W-1:0] cs_setup;
      logic [FIELD_W-1:0] addr_setup;
   } xio_timing_t;

   localparam int TIM_W = $bits(xio_timing_t);

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ADDR = 3'd1,
      PH_CSET = 3'd2,
      PH_STRB = 3'd3,
      PH_HOLD = 3'd4
   } xio_phase_e;

endpackage

// File: rtl/xio_timing_regs.sv
module xio_timing_regs
   import xio_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int CFG_W     = 32,
   localparam int BANKS_PER_REG = CFG_W / BANK_CFG_W,
   localparam int NUM_REGS      = NUM_BANKS / BANKS_PER_REG,
   localparam int SEL_W         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output xio_timing_t       bank_tim [NUM_BANKS]
);

   function automatic logic [CFG_W-1:0] spare_bits();
      logic [CFG_W-1:0] m;
      m = '1;
      for (int h = 0; h < BANKS_PER_REG; h++) begin
         m[h*BANK_CFG_W +: TIM_W] = '0;
      end
      return m;
   endfunction

   localparam logic [CFG_W-1:0] SPARE_MASK = spare_bits();

   logic spare_unused;
   assign spare_unused = ^(cfg_wdata & SPARE_MASK);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      for (genvar h = 0; h < BANKS_PER_REG; h++) begin : g_half
         localparam int BANK = r * BANKS_PER_REG + h;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bank_tim[BANK] <= '0;
            end else if (cfg_we && (cfg_sel == SEL_W'(r))) begin
               bank_tim[BANK] <= xio_timing_t'(cfg_wdata[h*BANK_CFG_W +: TIM_W]);
            end
         end
      end
   end

endmodule

// File: rtl/xio_phase_seq.sv
module xio_phase_seq
   import xio_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  xio_timing_t tim_in,
   output xio_phase_e  phase,
   output logic        strobe_last,
   output logic        done
);

   typedef struct packed {
      xio_phase_e         ph;
      logic [FIELD_W-1:0] cnt;
   } step_t;

   // Next non-empty phase after 'from', with the count it starts at.
   function automatic step_t advance(input xio_phase_e from, input xio_timing_t t);
      step_t s;
      s.ph  = PH_IDLE;
      s.cnt = '0;
      if (from == PH_IDLE && t.addr_setup != '0) begin
         s.ph  = PH_ADDR;
         s.cnt = t.addr_setup - 1'b1;
      end else if ((from == PH_IDLE || from == PH_ADDR) && t.cs_setup != '0) begin
         s.ph  = PH_CSET;
         s.cnt = t.cs_setup - 1'b1;
      end else if (from == PH_IDLE || from == PH_ADDR || from == PH_CSET) begin
         s.ph  = PH_STRB;
         s.cnt = t.acc;
      end else if (from == PH_STRB && t.hold != '0) begin
         s.ph  = PH_HOLD;
         s.cnt = t.hold - 1'b1;
      end
      return s;
   endfunction

   xio_timing_t        tim_q;
   logic [FIELD_W-1:0] cnt_q;
   step_t              nxt;
   logic               last;

   assign last = (cnt_q == '0);

   always_comb begin
      nxt.ph  = phase;
      nxt.cnt = cnt_q;
      if (phase == PH_IDLE) begin
         if (start) begin
            nxt = advance(PH_IDLE, tim_in);
         end
      end else if (last) begin
         nxt = advance(phase, tim_q);
      end else begin
         nxt.cnt = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
         tim_q <= '0;
      end else begin
         phase <= nxt.ph;
         cnt_q <= nxt.cnt;
         if (phase == PH_IDLE && start) begin
            tim_q <= tim_in;
         end
      end
   end

   assign strobe_last = (phase == PH_STRB) && last;
   assign done = last && ((phase == PH_HOLD) ||
                          (phase == PH_STRB && tim_q.hold == '0));

endmodule

// File: rtl/xio_cs_decode.sv
module xio_cs_decode #(
   parameter int NUM_BANKS = 4,
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 active,
   input  logic [BANK_W-1:0]    bank,
   output logic [NUM_BANKS-1:0] cs_n
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
      assign cs_n[b] = ~(active && (bank == BANK_W'(b)));
   end

endmodule

// File: rtl/xio_strobe_gen.sv
module xio_strobe_gen
   import xio_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int CFG_W     = 32,
   localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int BANKS_PER_REG = CFG_W / BANK_CFG_W,
   localparam int NUM_REGS      = NUM_BANKS / BANKS_PER_REG,
   localparam int SEL_W         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [SEL_W-1:0]     cfg_sel,
   input  logic [CFG_W-1:0]     cfg_wdata,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [BANK_W-1:0]    req_bank,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 xfer_done,
   output logic [DATA_W-1:0]    rd_data,
   output logic [ADDR_W-1:0]    ext_addr,
   output logic [DATA_W-1:0]    ext_wdata,
   input  logic [DATA_W-1:0]    ext_rdata,
   output logic [NUM_BANKS-1:0] ext_cs_n,
   output logic                 ext_oe_n,
   output logic                 ext_we_n
);

   if (CFG_W % BANK_CFG_W != 0 || BANKS_PER_REG < 1) begin : g_bad_cfg_w
      $error("CFG_W must be a whole multiple of the per-bank timing width");
   end
   if (NUM_BANKS < 2 || NUM_BANKS % BANKS_PER_REG != 0) begin : g_bad_banks
      $error("NUM_BANKS must be at least 2 and fill whole configuration words");
   end
   if (TIM_W > BANK_CFG_W) begin : g_bad_fields
      $error("timing fields do not fit in one bank slot");
   end
   if (ADDR_W < 8 || DATA_W < 1) begin : g_bad_bus
      $error("bus widths out of range");
   end

   xio_timing_t       bank_tim [NUM_BANKS];
   xio_phase_e        phase;
   logic              strobe_last;
   logic              seq_done;
   logic              accept;
   logic              cs_active;
   logic              strobe_on;

   logic [BANK_W-1:0] bank_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rd_q;

   xio_timing_regs #(
      .NUM_BANKS (NUM_BANKS),
      .CFG_W     (CFG_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .bank_tim  (bank_tim)
   );

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;

   xio_phase_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .tim_in      (bank_tim[req_bank]),
      .phase       (phase),
      .strobe_last (strobe_last),
      .done        (seq_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q  <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         bank_q  <= req_bank;
         wr_q    <= req_write;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (strobe_last && !wr_q) begin
         rd_q <= ext_rdata;
      end
   end

   assign cs_active = (phase == PH_CSET) || (phase == PH_STRB) || (phase == PH_HOLD);
   assign strobe_on = (phase == PH_STRB);

   xio_cs_decode #(
      .NUM_BANKS (NUM_BANKS)
   ) u_cs (
      .active (cs_active),
      .bank   (bank_q),
      .cs_n   (ext_cs_n)
   );

   assign ext_oe_n  = ~(strobe_on && !wr_q);
   assign ext_we_n  = ~(strobe_on && wr_q);
   assign ext_addr  = addr_q;
   assign ext_wdata = wdata_q;
   assign rd_data   = rd_q;
   assign xfer_done = seq_done;

endmodule

// File: rtl/xio_strobe_chk.sv
module xio_strobe_chk #(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_ready,
   input logic                 xfer_done,
   input logic [ADDR_W-1:0]    ext_addr,
   input logic [NUM_BANKS-1:0] ext_cs_n,
   input logic                 ext_oe_n,
   input logic                 ext_we_n
);

   // R1: nothing is driven low while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&ext_cs_n && ext_oe_n && ext_we_n));

   // R3: at most one bank selected
   p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ext_cs_n));

   // R3: address steady through a transfer
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(ext_addr));

   // R4: a strobe only inside a chip select
   p_strobe_in_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_oe_n || !ext_we_n) |-> !(&ext_cs_n));

   // R7: read and write strobes never overlap
   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_oe_n && !ext_we_n));

   // R8: done is a single-cycle pulse followed by idle
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   p_done_then_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> req_ready);

   // R6: all selects rise only right after the done cycle
   p_release_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(&ext_cs_n) |-> $past(xfer_done));

endmodule

bind xio_strobe_gen xio_strobe_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .xfer_done (xfer_done),
   .ext_addr  (ext_addr),
   .ext_cs_n  (ext_cs_n),
   .ext_oe_n  (ext_oe_n),
   .ext_we_n  (ext_we_n)
);

// File: tb/xio_strobe_gen_bench.sv
module xio_strobe_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [0:0]  cfg_sel;
   logic [31:0] cfg_wdata;
   logic        req_valid;
   logic        req_ready;
   logic [1:0]  req_bank;
   logic        req_write;
   logic [15:0] req_addr;
   logic [15:0] req_wdata;
   logic        xfer_done;
   logic [15:0] rd_data;
   logic [15:0] ext_addr;
   logic [15:0] ext_wdata;
   logic [15:0] ext_rdata;
   logic [3:0]  ext_cs_n;
   logic        ext_oe_n;
   logic        ext_we_n;

   always #5 clk = ~clk;

   xio_strobe_gen u_xio_strobe_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_bank  (req_bank),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .xfer_done (xfer_done),
      .rd_data   (rd_data),
      .ext_addr  (ext_addr),
      .ext_wdata (ext_wdata),
      .ext_rdata (ext_rdata),
      .ext_cs_n  (ext_cs_n),
      .ext_oe_n  (ext_oe_n),
      .ext_we_n  (ext_we_n)
   );

   // External device model: low byte counts the enable-low cycles seen so far
   logic [7:0] oe_cnt;
   always @(posedge clk) begin
      if (ext_oe_n) oe_cnt <= 8'd0;
      else          oe_cnt <= oe_cnt + 8'd1;
   end
   assign ext_rdata = {ext_addr[7:0] ^ 8'h5A, oe_cnt};

   int checks   = 0;
   int failures = 0;
   bit finished = 0;
   logic [15:0] last_rd = 16'h0;

   int m_a   [4];
   int m_c   [4];
   int m_acc [4];
   int m_h   [4];

   function automatic logic [15:0] enc(input int a, input int c, input int p, input int h);
      return {4'hF, 3'(h), 3'(p), 3'(c), 3'(a)};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_model(input int b, input int a, input int c, input int p, input int h);
      m_a[b] = a; m_c[b] = c; m_acc[b] = p; m_h[b] = h;
   endtask

   task automatic write_word(input int sel);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = 1'(sel);
      cfg_wdata = {enc(m_a[2*sel+1], m_c[2*sel+1], m_acc[2*sel+1], m_h[2*sel+1]),
                   enc(m_a[2*sel], m_c[2*sel], m_acc[2*sel], m_h[2*sel])};
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // One transfer, compared cycle by cycle against the bench's timing model.
   task automatic xfer(input int b, input bit wr, input logic [15:0] addr,
                       input logic [15:0] wd, input bit busy_req, input bit poke,
                       input logic [31:0] poke_data, input string req);
      int a, c, p, h, total;
      bit err;
      a = m_a[b]; c = m_c[b]; p = m_acc[b]; h = m_h[b];
      total = a + c + p + 1 + h;
      err = 0;
      @(negedge clk);
      check(req_ready == 1'b1, req, "ready before request", int'(req_ready), 1);
      req_valid = 1'b1;
      req_bank  = 2'(b);
      req_write = wr;
      req_addr  = addr;
      req_wdata = wd;
      @(posedge clk);
      #1;
      if (busy_req) begin
         req_bank  = 2'(b + 1);
         req_addr  = ~addr;
         req_write = ~wr;
      end else begin
         req_valid = 1'b0;
      end
      for (int i = 1; i <= total + 1; i++) begin
         bit         cs_low, strb, e_oe, e_we, e_done, e_rdy;
         logic [3:0] e_cs;
         @(negedge clk);
         cs_low = (i > a) && (i <= total);
         strb   = (i > a + c) && (i <= a + c + p + 1);
         e_cs   = cs_low ? ~(4'b0001 << b) : 4'hF;
         e_oe   = !(strb && !wr);
         e_we   = !(strb && wr);
         e_done = (i == total);
         e_rdy  = (i > total);
         if (!err && (ext_cs_n !== e_cs || ext_oe_n !== e_oe || ext_we_n !== e_we ||
                      xfer_done !== e_done || req_ready !== e_rdy ||
                      (i <= total && ext_addr !== addr) ||
                      (wr && strb && ext_wdata !== wd))) begin
            err = 1;
            $display("FAIL %s cycle %0d: actual cs_n=%b oe_n=%b we_n=%b done=%b ready=%b addr=%h wdata=%h expected cs_n=%b oe_n=%b we_n=%b done=%b ready=%b addr=%h wdata=%h",
                     req, i, ext_cs_n, ext_oe_n, ext_we_n, xfer_done, req_ready,
                     ext_addr, ext_wdata, e_cs, e_oe, e_we, e_done, e_rdy, addr, wd);
         end
         if (busy_req && i == total) req_valid = 1'b0;
         if (poke && i == 2) begin
            cfg_we    = 1'b1;
            cfg_sel   = 1'(b / 2);
            cfg_wdata = poke_data;
         end
         if (poke && i == 3) cfg_we = 1'b0;
      end
      checks++;
      if (err) failures++;
      if (!wr) last_rd = {addr[7:0] ^ 8'h5A, 8'(p)};
      check(rd_data == last_rd, req, wr ? "R9 rd_data kept over write" : "R9 rd_data capture",
            int'(rd_data), int'(last_rd));
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      req_valid = 1'b0; req_bank = '0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      for (int b = 0; b < 4; b++) set_model(b, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(ext_cs_n == 4'hF, "R1", "cs_n in reset", int'(ext_cs_n), 15);
      check(ext_oe_n && ext_we_n, "R1", "oe_n/we_n in reset", int'({ext_oe_n, ext_we_n}), 3);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      check(xfer_done == 1'b0, "R1", "done after reset", int'(xfer_done), 0);
      check(rd_data == 16'h0, "R1", "rd_data after reset", int'(rd_data), 0);
      check(ext_cs_n == 4'hF && ext_oe_n && ext_we_n, "R1", "strobes idle",
            int'({ext_cs_n, ext_oe_n, ext_we_n}), 63);
   endtask

   task automatic t_default_timing();
      xfer(3, 1'b0, 16'h1234, 16'h0, 1'b0, 1'b0, 32'h0, "R1 zero timing");
   endtask

   task automatic t_program();
      set_model(0, 0, 0, 4, 0);
      set_model(1, 2, 1, 2, 3);
      set_model(2, 1, 3, 0, 1);
      set_model(3, 7, 7, 7, 7);
      write_word(0);
      write_word(1);
   endtask

   task automatic t_example();
      xfer(0, 1'b0, 16'h00C3, 16'h0, 1'b0, 1'b0, 32'h0, "R11 plain 5-cycle pulse");
   endtask

   task automatic t_phases();
      xfer(1, 1'b0, 16'hA511, 16'h0, 1'b0, 1'b0, 32'h0, "R3 R4 R6 phased read");
   endtask

   task automatic t_write();
      xfer(2, 1'b1, 16'h0F0F, 16'hBEEF, 1'b0, 1'b0, 32'h0, "R7 write strobe");
   endtask

   task automatic t_max();
      xfer(3, 1'b0, 16'h7E42, 16'h0, 1'b0, 1'b0, 32'h0, "R5 longest fields");
   endtask

   task automatic t_busy();
      xfer(1, 1'b0, 16'h3399, 16'h0, 1'b1, 1'b0, 32'h0, "R8 request while busy");
   endtask

   task automatic t_midchange();
      logic [31:0] pd;
      pd = {enc(0, 2, 1, 0), enc(m_a[0], m_c[0], m_acc[0], m_h[0])};
      xfer(1, 1'b0, 16'h4477, 16'h0, 1'b0, 1'b1, pd, "R10 update during transfer");
      set_model(1, 0, 2, 1, 0);
      xfer(1, 1'b0, 16'h4478, 16'h0, 1'b0, 1'b0, 32'h0, "R2 new timing used");
   endtask

   task automatic t_zero_hold();
      set_model(2, 0, 0, 0, 0);
      write_word(1);
      xfer(2, 1'b0, 16'h0101, 16'h0, 1'b0, 1'b0, 32'h0, "R6 single-cycle hold 0");
      xfer(3, 1'b1, 16'h0202, 16'h5A5A, 1'b0, 1'b0, 32'h0, "R2 upper half kept");
   endtask

   initial begin
      t_reset();
      t_default_timing();
      t_program();
      t_example();
      t_phases();
      t_write();
      t_max();
      t_busy();
      t_midchange();
      t_zero_hold();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule